// File: doc/BRIEF.md
# MDIO Management Bridge with Indirect Host Access

This block lets a simple register bus run clause-22 MDIO management frames through two registers: one data word that carries the PHY and register addresses, and one command register. The host first places the 5-bit PHY address and 5-bit register address in the data word. For a write it also loads a separate write-data register. It then writes the command register with the MDIO decode value and a direction flag. The bridge then serialises a full frame on MDC/MDIO.

A read frame ends with the 16 bits returned by the PHY placed in the same data word that carried the addresses. Completion is shown in two ways, a status bit the host can poll and a level interrupt, so software can use either. MDC comes from the host clock through a programmable divider. The divider must be enabled before any command is accepted.

Register offsets on `host_addr`:
- 0: command.
- 1: data word.
- 2: write data.
- 3: management configuration.
- 4: status.

Reads on the bus are combinational and have no side effects. There is no back-pressure: every bus write takes effect in the cycle it is presented.

Top module: `mdio_host_bridge`

## Requirements
- R1: After reset, the status and data-word registers read 0, and `irq`, `mdc` and `mdio_oe` are 0.
- R2: With configuration bit 15 (enable) set and configuration bits [5:0] (divider D) non-zero, `mdc` toggles every D+1 clocks, giving a period of 2*(D+1) clocks. When the enable is clear or D is 0, `mdc` holds low.
- R3: A write to the command register starts a frame only when its bits [9:0] equal 0x3B4. Any other value leaves the bus pins and the status unchanged.
- R4: Command bit 15 set selects a write frame, driven MSB first with `mdio_oe` high throughout. The frame is 32 ones, then 01, opcode 01, the PHY address (data word [9:5]), the register address (data word [4:0]), turnaround 10, and finally the 16-bit write-data register. Bits change only on falling `mdc`.
- R5: Command bit 15 clear selects a read frame with opcode 10. The bridge drives only the first 46 bits. It releases `mdio_oe` for the 2 turnaround and 16 data bits, and samples `mdio_i` on the 16 rising `mdc` edges of the data field. It then places the 16 sampled bits, MSB first, in the data word.
- R6: When a frame completes, status bit 0 (ready) reads 1 and `irq` goes high. An accepted command clears the ready bit.
- R7: `irq` (also status bit 1) stays high until the host writes status with bit 1 set.
- R8: A decoded command written while a frame is pending or in progress is ignored and sets status bit 2 (error). The error bit stays set until the host writes status with bit 2 set.
- R9: A decoded command written while MDC is idle (enable clear or D = 0) produces no frame and leaves the ready bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset |
| host_we | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for `host_addr` (combinational) |
| irq | output | 1 | Completion interrupt, level |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The hardest case to reach is a second command that arrives while a frame is already in flight. The bus is free during a frame, so nothing at the ports stops the host from issuing one. The bench starts a slow write frame, waits a few cycles, and issues a read command in the middle of it. It then checks three things: the error bit is set, exactly one frame appears on the pins, and that frame is still the write frame. The read path needs a PHY model that knows the bit index within the frame. The bench resets its rising-edge counter when `mdio_oe` rises, then drives each read bit ahead of the rising `mdc` edge on which the bridge samples it.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam logic [2:0] OFS_CMD   = 3'd0;
  localparam logic [2:0] OFS_DATA  = 3'd1;
  localparam logic [2:0] OFS_WDAT  = 3'd2;
  localparam logic [2:0] OFS_CFG   = 3'd3;
  localparam logic [2:0] OFS_STAT  = 3'd4;
  localparam logic [9:0] MDIO_DECODE = 10'h3B4;
  localparam int PRE_BITS  = 32;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam int LAST_BIT  = 63;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             run;
  logic             term;

  always_comb begin
    run       = en && (div != '0);
    term      = run && (cnt >= div);
    rise_tick = term && !mdc;
    fall_tick = term && mdc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && div != '0) |=> !mdc);
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rise_tick && !fall_tick) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_bridge_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_write,
  input  logic [4:0]    phy,
  input  logic [4:0]    regad,
  input  logic [DW-1:0] wdata,
  input  logic          rise_tick,
  input  logic          fall_tick,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          busy,
  output logic          done,
  output logic          done_rd,
  output logic [DW-1:0] rdata
);
  logic        pend, active, wr_q;
  logic [5:0]  bitcnt;
  logic [31:0] hdr;
  logic [4:0]  hidx;

  always_comb begin
    hidx    = ~bitcnt[4:0];
    busy    = pend || active;
    mdio_o  = !active || !bitcnt[5] || hdr[hidx];
    mdio_oe = active && (wr_q || (bitcnt < 6'(TA_POS)));
    done_rd = done && !wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      active <= 1'b0;
      wr_q   <= 1'b0;
      bitcnt <= '0;
      hdr    <= '0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        pend <= 1'b1;
        wr_q <= is_write;
        hdr  <= {2'b01, (is_write ? 2'b01 : 2'b10), phy, regad,
                 (is_write ? 2'b10 : 2'b00), (is_write ? wdata : {DW{1'b0}})};
      end else if (fall_tick) begin
        if (pend) begin
          pend   <= 1'b0;
          active <= 1'b1;
          bitcnt <= '0;
        end else if (active) begin
          if (bitcnt == 6'(LAST_BIT)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
      if (rise_tick && active && !wr_q && bitcnt >= 6'(DATA_POS))
        rdata <= {rdata[DW-2:0], mdio_i};
    end
  end

  a_r4_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fall_tick && bitcnt != 6'(LAST_BIT)) |=> (bitcnt == $past(bitcnt) + 6'd1));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/mdio_host_bridge.sv
module mdio_host_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_we,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          irq,
  output logic          mdc,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe
);
  logic [DW-1:0]    data_lo, wr_data;
  logic             cfg_en;
  logic [DIV_W-1:0] cfg_div;
  logic             st_ready, st_irq, st_err;
  logic             rise_tick, fall_tick;
  logic             eng_busy, eng_done, eng_done_rd;
  logic [DW-1:0]    eng_rdata;
  logic             cmd_hit, mdc_run, start, stat_wr;

  always_comb begin
    cmd_hit = host_we && host_addr == OFS_CMD && host_wdata[9:0] == MDIO_DECODE;
    mdc_run = cfg_en && cfg_div != '0;
    start   = cmd_hit && mdc_run && !eng_busy;
    stat_wr = host_we && host_addr == OFS_STAT;
    irq     = st_irq;
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .div(cfg_div),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(host_wdata[DW-1]),
    .phy(data_lo[9:5]), .regad(data_lo[4:0]), .wdata(wr_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(eng_busy), .done(eng_done),
    .done_rd(eng_done_rd), .rdata(eng_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_lo  <= '0;
      wr_data  <= '0;
      cfg_en   <= 1'b0;
      cfg_div  <= '0;
      st_ready <= 1'b0;
      st_irq   <= 1'b0;
      st_err   <= 1'b0;
    end else begin
      if (host_we && host_addr == OFS_DATA) data_lo <= host_wdata;
      if (host_we && host_addr == OFS_WDAT) wr_data <= host_wdata;
      if (host_we && host_addr == OFS_CFG) begin
        cfg_en  <= host_wdata[DW-1];
        cfg_div <= host_wdata[DIV_W-1:0];
      end
      if (stat_wr && host_wdata[1]) st_irq <= 1'b0;
      if (stat_wr && host_wdata[2]) st_err <= 1'b0;
      if (cmd_hit && eng_busy) st_err <= 1'b1;
      if (start) st_ready <= 1'b0;
      if (eng_done_rd) data_lo <= eng_rdata;
      if (eng_done) begin
        st_ready <= 1'b1;
        st_irq   <= 1'b1;
      end
    end
  end

  always_comb begin
    case (host_addr)
      OFS_DATA: host_rdata = data_lo;
      OFS_WDAT: host_rdata = wr_data;
      OFS_CFG:  host_rdata = {cfg_en, {(DW-1-DIV_W){1'b0}}, cfg_div};
      OFS_STAT: host_rdata = {{(DW-3){1'b0}}, st_err, st_irq, st_ready};
      default:  host_rdata = '0;
    endcase
  end

  a_r6_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (st_ready && irq));
  a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_irq && !(stat_wr && host_wdata[1])) |=> st_irq);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_err && !(stat_wr && host_wdata[2])) |=> st_err);
  a_r8_busy_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && eng_busy) |=> st_err);
  a_r9_idle_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !mdc_run && !eng_busy) |=> !eng_busy);
  a_r3_decode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_hit && !eng_busy) |=> !eng_busy);
endmodule

// File: tb/mdio_host_bridge_test.sv
module mdio_host_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic        host_we = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        irq, mdc, mdio_i, mdio_o, mdio_oe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mdio_host_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural MDC model (R2)
  int  m_cnt = 0, m_div = 0;
  bit  m_en = 0, m_mdc = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_mdc = 0; m_en = 0; m_div = 0;
    end else begin
      if (!(m_en && m_div != 0)) begin m_cnt = 0; m_mdc = 0; end
      else if (m_cnt >= m_div) begin m_cnt = 0; m_mdc = !m_mdc; end
      else m_cnt++;
      if (host_we && host_addr == 3'd3) begin
        m_en = host_wdata[15]; m_div = int'(host_wdata[5:0]);
      end
    end
  end
  always @(negedge clk) if (rst_n && !finished)
    chk(mdc == m_mdc, "R2 mdc waveform", mdc, m_mdc);

  // PHY model: capture driven bits, supply read data
  bit       cap_q[$];
  int       phy_k = 0;
  int       frames = 0;
  logic [15:0] pat = 16'h0;
  bit       prev_oe = 0, prev_mdc = 0;
  assign mdio_i = (phy_k >= 48 && phy_k <= 63) ? pat[63 - phy_k] : 1'b1;
  always @(posedge clk) begin
    if (mdio_oe && !prev_oe) begin phy_k = 0; frames++; end
    if (mdc && !prev_mdc) begin
      if (mdio_oe) cap_q.push_back(mdio_o);
      phy_k++;
    end
    prev_oe = mdio_oe;
    prev_mdc = mdc;
  end

  task automatic hwrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_ready(output bit ok);
    logic [15:0] s;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      hread(3'd4, s);
      if (s[0]) begin ok = 1; break; end
    end
  endtask

  function automatic logic [63:0] frame_vec(bit wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0)};
  endfunction

  task automatic check_frame(input string req, input logic [63:0] v, input int n);
    chk(cap_q.size() == n, req, cap_q.size(), n);
    for (int i = 0; i < n && i < cap_q.size(); i++)
      chk(cap_q[i] == v[63 - i], req, cap_q[i], v[63 - i]);
  endtask

  task automatic summary;
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
    end
  end

  task automatic do_read(input int div, input logic [4:0] p, input logic [4:0] r, input logic [15:0] val);
    logic [15:0] d;
    bit ok;
    int f0;
    hwrite(3'd3, 16'h8000 | 16'(div));
    pat = val;
    hwrite(3'd1, {6'h0, p, r});
    cap_q.delete();
    f0 = frames;
    hwrite(3'd0, 16'h03B4);
    hread(3'd4, d);
    chk(d[0] == 1'b0, "R6 ready cleared by command", d[0], 0);
    wait_ready(ok);
    chk(ok, "R6 read completes", ok, 1);
    chk(irq == 1'b1, "R6 irq on read done", irq, 1);
    chk(frames == f0 + 1, "R5 one read frame", frames - f0, 1);
    check_frame("R5 read frame bits", frame_vec(0, p, r, 16'h0), 46);
    hread(3'd1, d);
    chk(d == val, "R5 read data in data word", d, val);
    hwrite(3'd4, 16'h0002);
  endtask

  initial begin
    logic [15:0] d;
    bit ok;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    hread(3'd4, d); chk(d == 16'h0, "R1 status reset", d, 0);
    hread(3'd1, d); chk(d == 16'h0, "R1 data reset", d, 0);
    chk({irq, mdc, mdio_oe} == 3'b000, "R1 pins reset", {irq, mdc, mdio_oe}, 0);
    // R9: disabled, then enabled with divider 0
    hwrite(3'd0, 16'h83B4);
    repeat (40) @(negedge clk);
    chk(frames == 0, "R9 no frame when disabled", frames, 0);
    hwrite(3'd3, 16'h8000);
    hwrite(3'd0, 16'h83B4);
    repeat (40) @(negedge clk);
    chk(frames == 0, "R9 no frame with divider 0", frames, 0);
    hread(3'd4, d); chk(d == 16'h0, "R9 status unchanged", d, 0);
    // R4 write frame, R8 command during frame
    hwrite(3'd3, 16'h8001);
    hwrite(3'd2, 16'hA5C3);
    hwrite(3'd1, {6'h0, 5'h11, 5'h0A});
    cap_q.delete();
    hwrite(3'd0, 16'h83B4);
    repeat (10) @(negedge clk);
    hwrite(3'd0, 16'h03B4);
    hread(3'd4, d); chk(d[2] == 1'b1, "R8 error on busy command", d[2], 1);
    wait_ready(ok);
    chk(ok, "R6 write completes", ok, 1);
    chk(irq == 1'b1, "R6 irq on write done", irq, 1);
    chk(frames == 1, "R8 busy command ignored", frames, 1);
    check_frame("R4 write frame bits", frame_vec(1, 5'h11, 5'h0A, 16'hA5C3), 64);
    // R7 irq held until cleared
    repeat (30) @(negedge clk);
    chk(irq == 1'b1, "R7 irq holds", irq, 1);
    hwrite(3'd4, 16'h0002);
    chk(irq == 1'b0, "R7 irq cleared", irq, 0);
    hread(3'd4, d); chk(d[2] == 1'b1, "R8 error sticky", d[2], 1);
    hwrite(3'd4, 16'h0004);
    hread(3'd4, d); chk(d[2] == 1'b0, "R8 error cleared", d[2], 0);
    // R3 decode mismatch
    f0 = frames;
    hwrite(3'd0, 16'h83B5);
    repeat (40) @(negedge clk);
    chk(frames == f0, "R3 wrong decode no frame", frames - f0, 0);
    hread(3'd4, d); chk(d == 16'h0001, "R3 status unchanged", d, 1);
    chk(mdio_oe == 1'b0, "R3 bus idle", mdio_oe, 0);
    // R5 reads
    do_read(2, 5'h01, 5'h04, 16'h1234);
    do_read(3, 5'h1F, 5'h1F, 16'h8001);
    summary();
  end
endmodule